// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns parallel audio samples, read from a transmit FIFO with first-word-fall-through behaviour, into a three-wire serial stream: a bit clock, a word-select line and a data line. The bit clock is derived from the block clock by an integer divider, so the block always drives the bit clock and the word-select. One frame engine produces four framing styles. The classic two-channel style has left and right halves. The other three are multi-slot (TDM) styles: a one-bit frame pulse, a word-long frame pulse, and a word-select with 50% duty. The bit clock and the word-select can each be inverted.

Samples leave the block MSB first in back-to-back slots, one slot per word length. In TDM styles the slots fill the whole frame, so each further channel pair starts exactly two words after the previous pair. Short words (4 to 16 bits) are packed two per FIFO entry, and longer words take one entry each. If the FIFO is empty when a new entry is needed, the block shifts zeros and raises a sticky underrun flag.

The block runs while `enable` is high and its configuration is legal. When `enable` falls, the block stops at once and returns to idle levels. The FSM has three states. ST_IDLE holds the lines quiet. ST_LEAD drives the single zero bit that comes before the first sample in classic style. ST_SHIFT streams the samples. The transitions are named as follows:
- ST_IDLE to ST_LEAD is the classic start.
- ST_IDLE to ST_SHIFT is the TDM start.
- ST_LEAD to ST_SHIFT happens on the first bit-clock tick.
- ST_LEAD or ST_SHIFT returns to ST_IDLE when `enable` goes low or the configuration becomes illegal.

Top module: `aud_serial_tx`

## Requirements
- R1: A configuration is legal only if the word length is 4 to 32, the frame length is 4 to 2048 bits and the divider is at least 2. With an illegal configuration the block stays idle, never pops the FIFO and keeps the bit clock at its idle level.
- R2: The frame length is twice the word length in classic style (`cfg_fmt`=0), whatever the channel count. In the TDM styles it is the channel count times the word length.
- R3: Raw word-select is a function of the bit position p within the frame (0 is the frame start). In classic style (0) it is high for p ≥ word length. For the one-bit pulse style (1) it is high only at p = 0. For the word-long pulse style (2) it is high for p < word length. For the 50% style (3) it is high for p < frame length / 2.
- R4: The output bit clock is the raw clock XOR `cfg_sck_inv`, and the output word-select is the raw word-select XOR `cfg_ws_inv`. The receiving edge is the rising edge of the raw clock.
- R5: One bit-clock period lasts `cfg_div` block-clock cycles. The raw clock is low during the first `cfg_div/2` cycles of each bit. Data and word-select change only while the output bit clock is at its idle level.
- R6: Samples are sent MSB first in contiguous slots. In classic style the first sample bit follows the frame start by one bit, and the leading bit is 0. In the TDM styles the first sample starts at the frame start.
- R7: For word lengths 4 to 16, each FIFO entry holds two samples, right-justified: bits [15:0] are sent first and bits [31:16] second. For 17 to 32, each entry holds one sample in bits [wlen-1:0]. Entries are taken in order.
- R8: In TDM styles, channel pair n (counting from 0) starts at bit 2·n·wlen of the frame, so pairs never overlap. Frames follow each other with no gap.
- R9: If a new entry is needed and the FIFO is empty, zeros are sent for the samples of that entry and `err` is set. `err` stays set until `err_clr` is pulsed, and underrun takes priority over clearing.
- R10: After reset, and in the cycle after `enable` is seen low, `sd` is 0, the bit clock sits at `cfg_sck_inv` and the word-select sits at `cfg_ws_inv`.
- R11: `fifo_pop` is pulsed only at the start of a bit that needs a new entry, and never while `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, base of the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request |
| cfg_fmt | input | 2 | Framing style: 0 classic, 1 one-bit pulse, 2 word-long pulse, 3 half duty |
| cfg_wlen | input | 6 | Word length in bits |
| cfg_chans | input | CH_W | Channel count for TDM styles |
| cfg_div | input | DIV_W | Block-clock cycles per bit |
| cfg_sck_inv | input | 1 | Invert bit clock |
| cfg_ws_inv | input | 1 | Invert word-select |
| fifo_data | input | 32 | Head entry of transmit FIFO |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_pop | output | 1 | Consume head entry this cycle |
| err_clr | input | 1 | Clear the underrun flag (write-one pulse) |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word-select / frame sync |
| sd | output | 1 | Serial data |
| err | output | 1 | Sticky underrun flag |

## Verification
The bench builds the block with its default parameters, `DIV_W`=16 and `CH_W`=8. The 8-bit channel count lets it program 64 channels of 32 bits for the 2048-bit maximum frame, and 72 channels to push the frame past the limit. The table covers all four framing styles at word lengths 4, 8, 12, 16, 20, 24 and 32, with odd channel counts, odd dividers and every polarity pairing. This reaches both packing paths, the extra channel pairs and the classic lead bit. The bench deserializes the output on the receiving edge and compares every bit against its own model. Directed cases cover an underrun in the middle of a stream and the rejected configurations.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
    typedef enum logic [1:0] {
        FMT_CLASSIC = 2'd0,
        FMT_PULSE   = 2'd1,
        FMT_LONG    = 2'd2,
        FMT_HALF    = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2
    } st_e;
endpackage

// File: rtl/aud_tx_bitclk.sv
module aud_tx_bitclk #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             sck_raw
);
    logic [DIV_W-1:0] cnt;

    assign tick    = run && (cnt == div - DIV_W'(1));
    assign sck_raw = run && (cnt >= (div >> 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/aud_tx_framer.sv
module aud_tx_framer import aud_tx_pkg::*; #(
    parameter int FL_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            restart,
    input  logic            halt,
    input  fmt_e            fmt,
    input  logic [5:0]      wlen,
    input  logic [FL_W-1:0] flen,
    output logic            ws_raw
);
    logic [FL_W-1:0] fpos, p_nxt, wl;
    logic            ws_nxt;

    assign wl = FL_W'(wlen);

    always_comb begin
        if (restart || fpos == flen - FL_W'(1))
            p_nxt = '0;
        else
            p_nxt = fpos + FL_W'(1);
        unique case (fmt)
            FMT_CLASSIC: ws_nxt = (p_nxt >= wl);
            FMT_PULSE:   ws_nxt = (p_nxt == '0);
            FMT_LONG:    ws_nxt = (p_nxt < wl);
            FMT_HALF:    ws_nxt = (p_nxt < (flen >> 1));
            default:     ws_nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fpos   <= '0;
            ws_raw <= 1'b0;
        end else if (halt) begin
            fpos   <= '0;
            ws_raw <= 1'b0;
        end else if (adv) begin
            fpos   <= p_nxt;
            ws_raw <= ws_nxt;
        end
    end
endmodule

// File: rtl/aud_tx_unpack.sv
module aud_tx_unpack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    input  logic        restart,
    input  logic        dummy,
    input  logic        halt,
    input  logic [5:0]  wlen,
    input  logic [31:0] fifo_data,
    input  logic        fifo_empty,
    input  logic        err_clr,
    output logic        fifo_pop,
    output logic        sd,
    output logic        err
);
    logic [31:0] sh, raw_word, aligned;
    logic [15:0] hold_hi;
    logic [5:0]  left;
    logic        half, packed_w, eff_half, need_word, need_entry, under;

    always_comb begin
        packed_w   = (wlen <= 6'd16);
        eff_half   = restart ? 1'b0 : half;
        need_word  = adv && !dummy && (restart || left == 6'd0);
        need_entry = need_word && (!packed_w || !eff_half);
        under      = need_entry && fifo_empty;
        if (!packed_w)
            raw_word = under ? 32'h0 : fifo_data;
        else if (!eff_half)
            raw_word = under ? 32'h0 : {16'h0, fifo_data[15:0]};
        else
            raw_word = {16'h0, hold_hi};
        aligned = raw_word << (6'd32 - wlen);
    end

    assign fifo_pop = need_entry && !fifo_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0; hold_hi <= '0; left <= '0;
            half <= 1'b0; sd <= 1'b0; err <= 1'b0;
        end else begin
            if (halt) begin
                sd <= 1'b0;
            end else if (adv) begin
                if (dummy) begin
                    sd   <= 1'b0;
                    left <= '0;
                    half <= 1'b0;
                end else if (need_word) begin
                    sd   <= aligned[31];
                    sh   <= {aligned[30:0], 1'b0};
                    left <= wlen - 6'd1;
                    half <= packed_w ? !eff_half : 1'b0;
                    if (need_entry)
                        hold_hi <= under ? 16'h0 : fifo_data[31:16];
                end else begin
                    sd   <= sh[31];
                    sh   <= {sh[30:0], 1'b0};
                    left <= left - 6'd1;
                end
            end
            if (under)
                err <= 1'b1;
            else if (err_clr)
                err <= 1'b0;
        end
    end
endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx import aud_tx_pkg::*; #(
    parameter int DIV_W = 16,
    parameter int CH_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       cfg_fmt,
    input  logic [5:0]       cfg_wlen,
    input  logic [CH_W-1:0]  cfg_chans,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_sck_inv,
    input  logic             cfg_ws_inv,
    input  logic [31:0]      fifo_data,
    input  logic             fifo_empty,
    output logic             fifo_pop,
    input  logic             err_clr,
    output logic             sck,
    output logic             ws,
    output logic             sd,
    output logic             err
);
    localparam int FL_W   = 12;
    localparam int FULL_W = CH_W + 6;

    fmt_e              fmt;
    st_e               state, nxt;
    logic [FULL_W-1:0] flen_full;
    logic [FL_W-1:0]   flen;
    logic              cfg_ok, running, start, adv, dummy, halt, tick, sck_raw, ws_raw;

    assign fmt       = fmt_e'(cfg_fmt);
    assign flen_full = (fmt == FMT_CLASSIC) ? FULL_W'({cfg_wlen, 1'b0})
                                            : FULL_W'(cfg_chans) * FULL_W'(cfg_wlen);
    assign flen      = FL_W'(flen_full);
    assign cfg_ok    = (cfg_wlen >= 6'd4) && (cfg_wlen <= 6'd32)
                    && (flen_full >= FULL_W'(4)) && (flen_full <= FULL_W'(2048))
                    && (cfg_div >= DIV_W'(2));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (enable && cfg_ok)
                          nxt = (fmt == FMT_CLASSIC) ? ST_LEAD : ST_SHIFT;
            ST_LEAD:  if (!enable || !cfg_ok) nxt = ST_IDLE;
                      else if (tick)          nxt = ST_SHIFT;
            ST_SHIFT: if (!enable || !cfg_ok) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        running = (state != ST_IDLE);
        start   = (state == ST_IDLE) && (nxt != ST_IDLE);
        halt    = (nxt == ST_IDLE);
        adv     = start || (running && tick && !halt);
        dummy   = start && (nxt == ST_LEAD);
        sck     = sck_raw ^ cfg_sck_inv;
        ws      = ws_raw ^ cfg_ws_inv;
    end

    aud_tx_bitclk #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(running), .div(cfg_div),
        .tick(tick), .sck_raw(sck_raw)
    );

    aud_tx_framer #(.FL_W(FL_W)) u_frm (
        .clk(clk), .rst_n(rst_n), .adv(adv), .restart(start), .halt(halt),
        .fmt(fmt), .wlen(cfg_wlen), .flen(flen), .ws_raw(ws_raw)
    );

    aud_tx_unpack u_unp (
        .clk(clk), .rst_n(rst_n), .adv(adv), .restart(start), .dummy(dummy),
        .halt(halt), .wlen(cfg_wlen), .fifo_data(fifo_data),
        .fifo_empty(fifo_empty), .err_clr(err_clr), .fifo_pop(fifo_pop),
        .sd(sd), .err(err)
    );
endmodule

// File: rtl/aud_tx_chk.sv
module aud_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic cfg_sck_inv,
    input logic fifo_pop,
    input logic fifo_empty,
    input logic err,
    input logic err_clr,
    input logic sck,
    input logic ws,
    input logic sd
);
    // R11
    pop_when_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err);

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(fifo_empty));

    // R10
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (sd == 1'b0));

    // R5
    ws_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws) |-> (sck == cfg_sck_inv));

    // R5
    sd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd) |-> (sck == cfg_sck_inv));
endmodule

bind aud_serial_tx aud_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_sck_inv(cfg_sck_inv),
    .fifo_pop(fifo_pop), .fifo_empty(fifo_empty), .err(err), .err_clr(err_clr),
    .sck(sck), .ws(ws), .sd(sd)
);

// File: tb/tb_aud_serial_tx.sv
module tb_aud_serial_tx;
    logic        clk = 1'b0;
    logic        rst_n, enable, cfg_sck_inv, cfg_ws_inv, err_clr;
    logic [1:0]  cfg_fmt;
    logic [5:0]  cfg_wlen;
    logic [7:0]  cfg_chans;
    logic [15:0] cfg_div;
    logic [31:0] fifo_data;
    logic        fifo_empty, fifo_pop, sck, ws, sd, err;

    int errors = 0;
    int checks = 0;
    int wr_n   = 0;
    int rd_i   = 0;
    logic flush = 1'b0;
    logic [31:0] fq [0:255];
    logic cap_sd [0:4199];
    logic cap_ws [0:4199];
    int e0, e1, got;

    always #10 clk = ~clk;

    aud_serial_tx dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_fmt(cfg_fmt),
        .cfg_wlen(cfg_wlen), .cfg_chans(cfg_chans), .cfg_div(cfg_div),
        .cfg_sck_inv(cfg_sck_inv), .cfg_ws_inv(cfg_ws_inv),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .err_clr(err_clr), .sck(sck), .ws(ws), .sd(sd), .err(err)
    );

    assign fifo_empty = (rd_i >= wr_n);
    assign fifo_data  = fq[rd_i & 255];

    always @(posedge clk) begin
        if (flush)         rd_i <= 0;
        else if (fifo_pop) rd_i <= rd_i + 1;
    end

    // fmt, wlen, chans, div, sck_inv, ws_inv, expected frame length
    localparam int VEC [9][7] = '{
        '{0, 16,  7, 4, 0, 0,   32},
        '{0, 24,  2, 2, 1, 0,   48},
        '{1, 16,  4, 4, 0, 0,   64},
        '{2,  8,  2, 3, 0, 1,   16},
        '{3, 32,  6, 2, 0, 0,  192},
        '{1, 20,  8, 2, 1, 1,  160},
        '{0,  4,  2, 2, 0, 1,    8},
        '{3, 12,  3, 5, 0, 0,   36},
        '{3, 32, 64, 2, 0, 0, 2048}
    };

    function automatic logic [31:0] ent(int j);
        return (j * 32'h9E3779B9) + 32'h1357_2468;
    endfunction

    function automatic logic exp_ws(int fm, int wl, int fl, int b, int wi);
        int  p = b % fl;
        logic r;
        case (fm)
            0:       r = (p >= wl);
            1:       r = (p == 0);
            2:       r = (p < wl);
            default: r = (p < fl / 2);
        endcase
        return r ^ wi[0];
    endfunction

    function automatic logic exp_sd(int fm, int wl, int b, int avail);
        int bb, w, i, j;
        logic [31:0] e, v;
        if (fm == 0) begin
            if (b == 0) return 1'b0;
            bb = b - 1;
        end else bb = b;
        w = bb / wl;
        i = bb % wl;
        j = (wl <= 16) ? w / 2 : w;
        if (j >= avail) return 1'b0;
        e = ent(j);
        if (wl <= 16) v = (w % 2 == 1) ? {16'h0, e[31:16]} : {16'h0, e[15:0]};
        else          v = e;
        return v[wl - 1 - i];
    endfunction

    task automatic check(input bit ok, input string msg, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, expv);
        end
    endtask

    task automatic capture(input int nb, input int si);
        int   cyc = 0;
        logic prev = 1'b0;
        logic raw;
        got = 0; e0 = 0; e1 = 0;
        while (got < nb && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            raw = sck ^ si[0];
            if (raw && !prev) begin
                cap_sd[got] = sd;
                cap_ws[got] = ws;
                if (got == 0) e0 = cyc;
                if (got == 1) e1 = cyc;
                got++;
            end
            prev = raw;
        end
    endtask

    task automatic run_case(input int fm, input int wl, input int ch, input int dv,
                            input int si, input int wi, input int fl,
                            input int avail, input int nb);
        int bad_sd = 0, bad_ws = 0, fb_sd = -1, fb_ws = -1;
        @(negedge clk);
        enable = 1'b0;
        cfg_fmt = 2'(fm); cfg_wlen = 6'(wl); cfg_chans = 8'(ch); cfg_div = 16'(dv);
        cfg_sck_inv = si[0]; cfg_ws_inv = wi[0];
        flush = 1'b1; wr_n = avail; err_clr = 1'b1;
        @(negedge clk);
        flush = 1'b0; err_clr = 1'b0;
        enable = 1'b1;
        capture(nb, si);
        check(got == nb, "R1 legal config produced bits", got, nb);
        for (int b = 0; b < got; b++) begin
            if (cap_sd[b] !== exp_sd(fm, wl, b, avail)) begin
                if (fb_sd < 0) fb_sd = b;
                bad_sd++;
            end
            if (cap_ws[b] !== exp_ws(fm, wl, fl, b, wi)) begin
                if (fb_ws < 0) fb_ws = b;
                bad_ws++;
            end
        end
        // R6 R7 R8: serial data versus unpacked samples
        if (fb_sd >= 0)
            check(1'b0, $sformatf("R6/R7/R8 sd fmt=%0d wl=%0d bit %0d", fm, wl, fb_sd),
                  cap_sd[fb_sd], exp_sd(fm, wl, fb_sd, avail));
        else
            check(1'b1, "R6 sd", 0, 0);
        // R2 R3 R4: word-select shape, frame length and polarity
        if (fb_ws >= 0)
            check(1'b0, $sformatf("R2/R3/R4 ws fmt=%0d wl=%0d bit %0d", fm, wl, fb_ws),
                  cap_ws[fb_ws], exp_ws(fm, wl, fl, fb_ws, wi));
        else
            check(1'b1, "R3 ws", 0, 0);
        // R5: bit-clock period in block-clock cycles
        check((e1 - e0) == dv, "R5 bit clock period", e1 - e0, dv);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R10: idle levels after stop
        check(sd == 1'b0 && sck == si[0] && ws == wi[0], "R10 idle levels after stop",
              {sd, sck, ws}, {1'b0, si[0], wi[0]});
    endtask

    task automatic bad_case(input int fm, input int wl, input int ch, input int dv);
        logic s0;
        int   moved = 0;
        @(negedge clk);
        enable = 1'b0;
        cfg_fmt = 2'(fm); cfg_wlen = 6'(wl); cfg_chans = 8'(ch); cfg_div = 16'(dv);
        cfg_sck_inv = 1'b0; cfg_ws_inv = 1'b0;
        flush = 1'b1; wr_n = 10;
        @(negedge clk);
        flush = 1'b0;
        enable = 1'b1;
        s0 = sck;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (sck !== s0 || sd !== 1'b0) moved++;
        end
        // R1: rejected configuration stays idle and takes nothing
        check(moved == 0 && rd_i == 0,
              $sformatf("R1 reject wl=%0d ch=%0d div=%0d", wl, ch, dv), rd_i + moved, 0);
        enable = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int j = 0; j < 256; j++) fq[j] = ent(j);
        rst_n = 1'b0; enable = 1'b0; err_clr = 1'b0;
        cfg_fmt = 2'd0; cfg_wlen = 6'd16; cfg_chans = 8'd2; cfg_div = 16'd4;
        cfg_sck_inv = 1'b0; cfg_ws_inv = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(sd == 1'b0 && sck == 1'b0 && ws == 1'b0, "R10 reset line levels",
              {sd, sck, ws}, 0);
        check(err == 1'b0 && fifo_pop == 1'b0, "R10 R11 reset err/pop", {err, fifo_pop}, 0);

        for (int r = 0; r < 9; r++)
            run_case(VEC[r][0], VEC[r][1], VEC[r][2], VEC[r][3], VEC[r][4], VEC[r][5],
                     VEC[r][6], 200, 2 * VEC[r][6] + 1);

        // R9: underrun after one packed entry; zeros follow, flag sticks
        run_case(0, 16, 2, 2, 0, 0, 32, 1, 100);
        check(err == 1'b1, "R9 underrun flag set and sticky", err, 1);
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check(err == 1'b0, "R9 write-one clear", err, 0);
        // R9: unpacked underrun in TDM
        run_case(1, 24, 4, 2, 0, 0, 96, 3, 150);
        check(err == 1'b1, "R9 underrun flag unpacked", err, 1);

        bad_case(0, 3, 2, 4);
        bad_case(2, 33, 2, 4);
        bad_case(3, 32, 72, 2);
        bad_case(1, 16, 4, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule